// File: doc/BRIEF.md
# Shared-Status Multi-Bank Interrupt Controller

This block gathers event pulses from a packet DMA engine into five 32-bit sticky status words. All interrupt lines share these words. Four interrupt lines, called banks, each keep their own set of five 32-bit enable words. A bank's line goes high when any pending status bit is also set in that bank's enable word at the same index. Software uses the enables to route receive queues to particular lines. The status words are common, so a single event can wake one line, several lines or none.

Software reaches every register through a plain 32-bit write strobe and address port. Read data is combinational from the address. Event sources and register accesses are plain control pins with no handshake: an event is a one-cycle pulse per bit, and a register write completes on the clock edge where `reg_wr` is high.

Top module: `irqc_top`

## Requirements
- R1: After reset, every status and enable register reads 0 and all four `irq_o` bits are low.
- R2: A one-cycle pulse on event bit `32*i + k` sets bit k of status word i on that clock edge. The bit stays set until software clears it.
- R3: Writing a status word clears exactly the bits written as 1 and leaves the rest unchanged. Writing 0xFFFFFFFF clears the whole word. Other status words are not affected.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R5: Each enable word reads back the last value written to it. Enable word i of bank b is at: i=0 at 0x028+8b, i=1 at 0x02C+8b, i=2 at 0x740+32b, i=3 at 0x744+32b, i=4 at 0x750+32b.
- R6: The status words are at 0x020 (i=0), 0x024 (i=1), 0x720 (i=2), 0x724 (i=3) and 0x730 (i=4). A read of one of these addresses returns only that word.
- R7: `irq_o[b]` is registered. It goes high one clock after any index i has a bit set in both status word i and bank b's enable word i. This holds for every index 0 to 4.
- R8: `irq_o[b]` drops one clock after the last contributing bit is cleared or disabled. Disabling a bit leaves the status bit pending.
- R9: Receive-done for queue q is status word 1 bit q when q < 16, and status word 2 bit q-16 otherwise. The default queue ownership is bank0 0x0000839F, bank1 0x7FE00000, bank2 0x00000020 and bank3 0x00000040. With enables programmed from these masks, only the owning bank's line fires, and a queue owned by no bank fires none. If two banks enable the same bit, both lines fire.
- R10: A write to an unmapped address changes no register. A read of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 160 | Event pulses; bits 32*i+31..32*i feed status word i |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 32 | Write data (W1C for status, plain store for enables) |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_o | output | 4 | Level interrupt line per bank |

## Verification
Two things can land on the same status bit in one cycle: a new event pulse and a software clear. The bench drives both on the same falling edge, setting the event bit while an all-ones clear is written to that word. The test passes only if the read-back keeps the newly pulsed bit and drops the older pending bits. A second overlap is an enable being cleared while its status bit is still pending. Here the line must stay high for exactly one more cycle and then fall, and the status bit must still read as pending.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int IRQC_DW    = 32;
  localparam int IRQC_NIDX  = 5;
  localparam int IRQC_NBANK = 4;
  localparam int IRQC_AW    = 12;

  // Shared status word addresses.
  function automatic logic [IRQC_AW-1:0] stat_addr(input int idx);
    case (idx)
      0:       return 12'h020;
      1:       return 12'h024;
      2:       return 12'h720;
      3:       return 12'h724;
      default: return 12'h730;
    endcase
  endfunction

  // Per-bank enable word addresses: low group strides 8 bytes, high group 32.
  function automatic logic [IRQC_AW-1:0] en_addr(input int bank, input int idx);
    logic [IRQC_AW-1:0] b;
    b = IRQC_AW'(bank);
    case (idx)
      0:       return 12'h028 + (b << 3);
      1:       return 12'h02C + (b << 3);
      2:       return 12'h740 + (b << 5);
      3:       return 12'h744 + (b << 5);
      default: return 12'h750 + (b << 5);
    endcase
  endfunction
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int NIDX  = IRQC_NIDX,
  parameter int NBANK = IRQC_NBANK
) (
  input  logic [IRQC_AW-1:0]      addr,
  output logic [NIDX-1:0]         stat_hit,
  output logic [NBANK*NIDX-1:0]   en_hit,
  output logic                    any_hit
);
  for (genvar i = 0; i < NIDX; i++) begin : g_stat
    assign stat_hit[i] = (addr == stat_addr(i));
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    for (genvar i = 0; i < NIDX; i++) begin : g_idx
      assign en_hit[b*NIDX+i] = (addr == en_addr(b, i));
    end
  end

  assign any_hit = (|stat_hit) | (|en_hit);

  // R6/R5: no two registers may share an address.
  always_comb begin
    p_addr_unique_r6: assert ($onehot0({stat_hit, en_hit}));
  end
endmodule

// File: rtl/irqc_status.sv
module irqc_status #(
  parameter int DW   = 32,
  parameter int NIDX = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NIDX*DW-1:0]   evt,
  input  logic [NIDX-1:0]      clr_sel,
  input  logic [DW-1:0]        wdata,
  output logic [NIDX*DW-1:0]   status
);
  for (genvar i = 0; i < NIDX; i++) begin : g_word
    logic [DW-1:0] clr_mask;
    assign clr_mask = clr_sel[i] ? wdata : '0;

    // Event OR is applied after the clear, so a same-cycle event survives.
    always_ff @(posedge clk) begin
      if (!rst_n) status[i*DW +: DW] <= '0;
      else        status[i*DW +: DW] <= (status[i*DW +: DW] & ~clr_mask)
                                        | evt[i*DW +: DW];
    end

    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[i*DW +: DW] != '0) |=>
        ((status[i*DW +: DW] & $past(evt[i*DW +: DW])) == $past(evt[i*DW +: DW])));

    p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_sel[i] |=>
        ((status[i*DW +: DW] & $past(wdata & ~evt[i*DW +: DW])) == '0));

    p_event_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_sel[i] && ((evt[i*DW +: DW] & wdata) != '0)) |=>
        ((status[i*DW +: DW] & $past(evt[i*DW +: DW] & wdata))
          == $past(evt[i*DW +: DW] & wdata)));
  end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
  parameter int DW   = 32,
  parameter int NIDX = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NIDX*DW-1:0]   status,
  input  logic [NIDX-1:0]      en_wr,
  input  logic [DW-1:0]        wdata,
  output logic [NIDX*DW-1:0]   enable,
  output logic                 irq
);
  logic [NIDX-1:0] word_hit;

  for (genvar i = 0; i < NIDX; i++) begin : g_en
    always_ff @(posedge clk) begin
      if (!rst_n)       enable[i*DW +: DW] <= '0;
      else if (en_wr[i]) enable[i*DW +: DW] <= wdata;
    end
    assign word_hit[i] = |(status[i*DW +: DW] & enable[i*DW +: DW]);

    p_en_readback_r5: assert property (@(posedge clk) disable iff (!rst_n)
      en_wr[i] |=> (enable[i*DW +: DW] == $past(wdata)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |word_hit;
  end

  p_irq_rise_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(status) != '0 && $past(enable) != '0));

  p_irq_no_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |=> !irq);

  p_irq_no_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |=> !irq);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int DW    = IRQC_DW,
  parameter int NIDX  = IRQC_NIDX,
  parameter int NBANK = IRQC_NBANK
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NIDX*DW-1:0]    evt_pulse,
  input  logic                  reg_wr,
  input  logic [IRQC_AW-1:0]    reg_addr,
  input  logic [DW-1:0]         reg_wdata,
  output logic [DW-1:0]         reg_rdata,
  output logic [NBANK-1:0]      irq_o
);
  localparam int NEN = NBANK * NIDX;

  logic [NIDX-1:0]       stat_hit;
  logic [NEN-1:0]        en_hit;
  logic                  any_hit;
  logic [NIDX*DW-1:0]    status;
  logic [NBANK*NIDX*DW-1:0] enables;

  irqc_decode #(.NIDX(NIDX), .NBANK(NBANK)) u_dec (
    .addr     (reg_addr),
    .stat_hit (stat_hit),
    .en_hit   (en_hit),
    .any_hit  (any_hit)
  );

  irqc_status #(.DW(DW), .NIDX(NIDX)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt_pulse),
    .clr_sel (stat_hit & {NIDX{reg_wr}}),
    .wdata   (reg_wdata),
    .status  (status)
  );

  // R9: every bank sees the same status; only its enables decide routing.
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    irqc_bank #(.DW(DW), .NIDX(NIDX)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .status (status),
      .en_wr  (en_hit[b*NIDX +: NIDX] & {NIDX{reg_wr}}),
      .wdata  (reg_wdata),
      .enable (enables[b*NIDX*DW +: NIDX*DW]),
      .irq    (irq_o[b])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NIDX; i++)
      if (stat_hit[i]) reg_rdata = reg_rdata | status[i*DW +: DW];
    for (int e = 0; e < NEN; e++)
      if (en_hit[e]) reg_rdata = reg_rdata | enables[e*DW +: DW];
  end

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !any_hit |-> (reg_rdata == '0));

  p_unmapped_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !any_hit && evt_pulse == '0) |=> ($stable(status) && $stable(enables)));
endmodule

// File: tb/sim_irqc_top.sv
`timescale 1ns/1ps
module sim_irqc_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [159:0] evt_pulse = '0;
  logic         reg_wr = 1'b0;
  logic [11:0]  reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [3:0]   irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;   // 50 MHz

  irqc_top u0 (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o)
  );

  localparam logic [31:0] QOWN [4] = '{32'h0000839F, 32'h7FE00000,
                                       32'h00000020, 32'h00000040};

  function automatic logic [11:0] sa(input int i);
    case (i)
      0: return 12'h020; 1: return 12'h024; 2: return 12'h720;
      3: return 12'h724; default: return 12'h730;
    endcase
  endfunction

  function automatic logic [11:0] ea(input int b, input int i);
    case (i)
      0: return 12'(12'h028 + 8*b);  1: return 12'(12'h02C + 8*b);
      2: return 12'(12'h740 + 32*b); 3: return 12'(12'h744 + 32*b);
      default: return 12'(12'h750 + 32*b);
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input int i, input logic [31:0] bits);
    @(negedge clk);
    evt_pulse[i*32 +: 32] = bits;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int i = 0; i < 5; i++) begin rd(sa(i), d); check("R1 status", d, 0); end
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 5; i++) begin rd(ea(b, i), d); check("R1 enable", d, 0); end
    check("R1 irq", {28'd0, irq_o}, 0);
  endtask

  task automatic t_sticky_w1c();
    logic [31:0] d;
    pulse(2, 32'hF0F00001);
    repeat (3) @(negedge clk);
    rd(sa(2), d); check("R2 sticky", d, 32'hF0F00001);
    wr(sa(2), 32'h00F00001);
    rd(sa(2), d); check("R3 partial clear", d, 32'hF0000000);
    rd(sa(1), d); check("R3 other word", d, 0);
    check("R8 no enable no line", {28'd0, irq_o}, 0);
    wr(sa(2), 32'hFFFFFFFF);
    rd(sa(2), d); check("R3 all-ones clear", d, 0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    pulse(0, 32'h0000000A);
    @(negedge clk);
    evt_pulse[31:0] = 32'h8;
    reg_addr = sa(0); reg_wdata = 32'hFFFFFFFF; reg_wr = 1'b1;
    @(negedge clk);
    evt_pulse = '0; reg_wr = 1'b0;
    rd(sa(0), d); check("R4 event wins", d, 32'h8);
    wr(sa(0), 32'hFFFFFFFF);
    rd(sa(0), d); check("R4 later clear", d, 0);
  endtask

  task automatic t_enable_rb();
    logic [31:0] d;
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 5; i++) wr(ea(b, i), {4'(b), 4'(i), 24'h5A3C71});
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 5; i++) begin
        rd(ea(b, i), d); check("R5 readback", d, {4'(b), 4'(i), 24'h5A3C71});
      end
    for (int i = 0; i < 5; i++) begin rd(sa(i), d); check("R6 status isolated", d, 0); end
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 5; i++) wr(ea(b, i), 32'h0);
  endtask

  task automatic t_each_index();
    logic [31:0] d;
    for (int i = 0; i < 5; i++) begin
      int b;
      logic [31:0] bv;
      b = i % 4;
      bv = 32'h1 << (i*5 + 3);
      wr(ea(b, i), bv);
      pulse(i, bv);
      check("R7 latency", {28'd0, irq_o}, 0);
      @(negedge clk);
      check("R7 raise", {28'd0, irq_o}, 32'h1 << b);
      rd(sa(i), d); check("R6 status addr", d, bv);
      wr(sa(i), bv);
      check("R8 one more cycle", {28'd0, irq_o}, 32'h1 << b);
      @(negedge clk);
      check("R8 drop after clear", {28'd0, irq_o}, 0);
      wr(ea(b, i), 32'h0);
    end
  endtask

  task automatic t_disable();
    logic [31:0] d;
    wr(ea(2, 4), 32'h100);
    pulse(4, 32'h100);
    @(negedge clk);
    check("R7 bank2 index4", {28'd0, irq_o}, 32'h4);
    wr(ea(2, 4), 32'h0);
    check("R8 disable lag", {28'd0, irq_o}, 32'h4);
    @(negedge clk);
    check("R8 drop after disable", {28'd0, irq_o}, 0);
    rd(sa(4), d); check("R8 status kept", d, 32'h100);
    wr(sa(4), 32'hFFFFFFFF);
  endtask

  task automatic t_routing();
    int qs [7] = '{0, 5, 6, 15, 21, 30, 10};
    for (int b = 0; b < 4; b++) begin
      wr(ea(b, 1), {16'd0, QOWN[b][15:0]});
      wr(ea(b, 2), {16'd0, QOWN[b][31:16]});
    end
    foreach (qs[n]) begin
      int q;
      logic [3:0] exp;
      q = qs[n];
      for (int b = 0; b < 4; b++) exp[b] = QOWN[b][q];
      if (q < 16) pulse(1, 32'h1 << q); else pulse(2, 32'h1 << (q - 16));
      @(negedge clk);
      check("R9 owner line", {28'd0, irq_o}, {28'd0, exp});
      if (q < 16) wr(sa(1), 32'h1 << q); else wr(sa(2), 32'h1 << (q - 16));
      @(negedge clk);
      check("R9 quiet after clear", {28'd0, irq_o}, 0);
    end
    wr(ea(3, 1), 32'h00000041);
    pulse(1, 32'h1);
    @(negedge clk);
    check("R9 shared bit two banks", {28'd0, irq_o}, 32'h9);
    wr(sa(1), 32'hFFFFFFFF);
    for (int b = 0; b < 4; b++) begin wr(ea(b, 1), 0); wr(ea(b, 2), 0); end
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    pulse(3, 32'h00010000);
    wr(12'h728, 32'hFFFFFFFF);
    wr(12'h7FC, 32'hFFFFFFFF);
    wr(12'h022, 32'hFFFFFFFF);
    rd(12'h728, d); check("R10 read zero", d, 0);
    rd(12'h7FC, d); check("R10 read zero", d, 0);
    rd(sa(3), d); check("R10 status untouched", d, 32'h00010000);
    rd(ea(0, 0), d); check("R10 enable untouched", d, 0);
    check("R10 no line", {28'd0, irq_o}, 0);
    wr(sa(3), 32'hFFFFFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sticky_w1c();
    t_collide();
    t_enable_rb();
    t_each_index();
    t_disable();
    t_routing();
    t_unmapped();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule